// File: doc/BRIEF.md
# Interrupt Group Resolver and SGI Filter

This block sits beside the per-processor interrupt state of an interrupt controller. For every banked interrupt it turns the stored group bit and group-modifier bit into one of three security groups, taking into account whether the two-security-state mode is switched off. The decode is purely combinational, so neighbouring logic always sees the current group of every interrupt.

When a software-generated interrupt (SGI) request arrives, the block checks it against the group that the target interrupt is configured for, the group the requester asked for, and the requester's security state. A non-secure requester is also checked against the per-SGI access level. In the cycle the request is presented, the block signals either an accept or a drop. An accept sets the pending bit of the target SGI at the next clock edge.

The block also holds the processor's sleep flag and three per-group distribution-disable bits. From these and the group enables it computes, for each group, whether this processor may be picked as the target of a one-of-N interrupt.

Top module: `irq_group_filter`

## Requirements
- R1: `irq_grp_o` carries one 2-bit field per interrupt, at bits [2k+1:2k] for interrupt k. The codes are 0 for secure group 0, 1 for secure group 1 and 2 for non-secure group 1. Code 3 never appears.
- R2: While `sec_dis_i` is 1, an interrupt whose group bit is 0 resolves to code 0 and one whose group bit is 1 resolves to code 2, whatever its modifier bit is.
- R3: While `sec_dis_i` is 0, the pair (modifier, group) resolves as follows: 00 to code 0, 01 to code 2, 10 to code 1, and 11 to code 2.
- R4: `sgi_grp_i` uses the R1 codes. A request for code 1 whose target resolves to code 0 is treated as a request for code 0 and is accepted, subject to R6.
- R5: A request whose effective group is code 0 is dropped when the target does not resolve to code 0. A request carrying code 3 is always dropped.
- R6: While `sec_dis_i` is 0 and `sgi_ns_i` is 1, the 2-bit access level of the target SGI (`nsacc_i` bits [2k+1:2k]) drops the request in two cases: the target resolves to code 0 and the level is 0, or the target resolves to code 1 and the level is below 2. While `sec_dis_i` is 1 the level has no effect.
- R7: In any cycle with `sgi_req_i` high, exactly one of `sgi_acc_o` and `sgi_drop_o` is high in that same cycle. Both are low when there is no request.
- R8: An accept sets bit `sgi_id_i` of `sgi_pend_o` at the next clock edge, even if `sgi_clr_i` clears that bit in the same cycle. A drop changes no pending bit. A bit of `sgi_clr_i` that is high with no accept on that bit clears it at the next edge.
- R9: `elig_o[g]` is 1 only when the processor is awake, `grp_en_i[g]` is 1, and disable bit g is 0. The index g uses the R1 codes.
- R10: After reset the processor is marked asleep, all three disable bits are 0, and all pending bits are 0.
- R11: A write through `sleep_wr_i` or `dis_wr_i` takes effect on `elig_o` one cycle later. Before that clock edge the old value still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_dis_i | input | 1 | Single-security-state mode |
| grp_bits_i | input | NUM_IRQ | Group bit per interrupt |
| mod_bits_i | input | NUM_IRQ | Group-modifier bit per interrupt |
| nsacc_i | input | 2*NUM_SGI | Non-secure access level per SGI |
| grp_en_i | input | 3 | Group enables, indexed by group code |
| sleep_wr_i | input | 1 | Write strobe for the sleep flag |
| sleep_i | input | 1 | New sleep flag (1 = asleep) |
| dis_wr_i | input | 1 | Write strobe for the disable bits |
| dis_i | input | 3 | New per-group disable bits |
| sgi_req_i | input | 1 | SGI request valid |
| sgi_id_i | input | SGI_W | Target SGI number |
| sgi_grp_i | input | 2 | Requested group code |
| sgi_ns_i | input | 1 | Requester is non-secure |
| sgi_clr_i | input | NUM_SGI | Pending-bit clear mask |
| irq_grp_o | output | 2*NUM_IRQ | Resolved group per interrupt |
| sgi_acc_o | output | 1 | Request accepted this cycle |
| sgi_drop_o | output | 1 | Request dropped this cycle |
| sgi_pend_o | output | NUM_SGI | SGI pending bits |
| elig_o | output | 3 | One-of-N eligibility per group |

## Verification
The assertions check these on every cycle:
- Code 3 never leaves the decoder.
- Secure group 1 never appears while `sec_dis_i` is 1.
- Every request gets exactly one outcome.
- No accept breaks the group-0 rule, the reserved-code rule or the access-level rule.
- A pending bit rises only after an accept on that bit, and every accept lands in its pending bit.
- Sleep and enable gate eligibility.

Only the bench's sweeps show the rest:
- The exact decode table for all modifier and group pairs.
- The complete accept/drop matrix over requested group, requester state and access level.
- That set wins over a same-cycle clear.
- The reset values.
- The one-cycle latency of the sleep and disable writes.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;
  typedef logic [1:0] grp_t;
  localparam grp_t GRP_S0  = 2'd0;
  localparam grp_t GRP_S1  = 2'd1;
  localparam grp_t GRP_NS1 = 2'd2;
  localparam grp_t GRP_RSV = 2'd3;
  localparam int unsigned NUM_GRP = 3;
endpackage

// File: rtl/irq_grp_resolve.sv
module irq_grp_resolve
  import irq_group_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sec_dis_i,
  input  logic [NUM_IRQ-1:0]   grp_bits_i,
  input  logic [NUM_IRQ-1:0]   mod_bits_i,
  output logic [2*NUM_IRQ-1:0] grp_o
);
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    grp_t res;
    always_comb begin
      if (sec_dis_i) begin
        res = grp_bits_i[k] ? GRP_NS1 : GRP_S0;
      end else begin
        unique case ({mod_bits_i[k], grp_bits_i[k]})
          2'b00:   res = GRP_S0;
          2'b10:   res = GRP_S1;
          default: res = GRP_NS1;
        endcase
      end
    end
    assign grp_o[2*k +: 2] = res;

    AST_NO_RSV_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_o[2*k +: 2] != GRP_RSV); // R1
    AST_SECDIS_NO_S1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_dis_i |-> grp_o[2*k +: 2] != GRP_S1); // R2
  end
endmodule

// File: rtl/sgi_filter.sv
module sgi_filter
  import irq_group_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned SGI_W = $clog2(NUM_SGI)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sec_dis_i,
  input  logic [1:0]           tgt_grp_i,
  input  logic [2*NUM_SGI-1:0] nsacc_i,
  input  logic                 req_i,
  input  logic [SGI_W-1:0]     id_i,
  input  logic [1:0]           req_grp_i,
  input  logic                 ns_i,
  input  logic [NUM_SGI-1:0]   clr_i,
  output logic                 acc_o,
  output logic                 drop_o,
  output logic [NUM_SGI-1:0]   pend_o
);
  grp_t       eff_grp;
  logic [1:0] lvl;
  logic       grp_ok, ns_ok, pass;

  assign lvl = nsacc_i[{id_i, 1'b0} +: 2];

  always_comb begin
    eff_grp = req_grp_i;
    if (tgt_grp_i == GRP_S0 && req_grp_i == GRP_S1) eff_grp = GRP_S0;
  end

  assign grp_ok = (req_grp_i != GRP_RSV) &&
                  !(eff_grp == GRP_S0 && tgt_grp_i != GRP_S0);

  always_comb begin
    ns_ok = 1'b1;
    if (ns_i && !sec_dis_i) begin
      if (tgt_grp_i == GRP_S0 && lvl < 2'd1) ns_ok = 1'b0;
      if (tgt_grp_i == GRP_S1 && lvl < 2'd2) ns_ok = 1'b0;
    end
  end

  assign pass   = grp_ok && ns_ok;
  assign acc_o  = req_i && pass;
  assign drop_o = req_i && !pass;

  for (genvar k = 0; k < NUM_SGI; k++) begin : g_pend
    logic set_k, pend_q;
    assign set_k = acc_o && (id_i == SGI_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q <= 1'b0;
      else if (set_k)    pend_q <= 1'b1;   // set wins over clear
      else if (clr_i[k]) pend_q <= 1'b0;
    end
    assign pend_o[k] = pend_q;

    AST_PEND_ONLY_ON_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_o[k]) |-> $past(acc_o && id_i == SGI_W'(k))); // R8
    AST_ACC_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_o && id_i == SGI_W'(k)) |=> pend_o[k]); // R8
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (acc_o ^ drop_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(acc_o || drop_o)); // R7
  AST_G0_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && req_grp_i == GRP_S0) |-> tgt_grp_i == GRP_S0); // R5
  AST_RSV_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_grp_i == GRP_RSV) |-> drop_o); // R5
  AST_NS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && ns_i && !sec_dis_i && tgt_grp_i == GRP_S1) |->
      nsacc_i[{id_i, 1'b0} +: 2] >= 2'd2); // R6
endmodule

// File: rtl/elig_unit.sv
module elig_unit
  import irq_group_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GRP-1:0] grp_en_i,
  input  logic               sleep_wr_i,
  input  logic               sleep_i,
  input  logic               dis_wr_i,
  input  logic [NUM_GRP-1:0] dis_i,
  output logic [NUM_GRP-1:0] elig_o
);
  logic               asleep_q;
  logic [NUM_GRP-1:0] dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q <= 1'b1;
      dis_q    <= '0;
    end else begin
      if (sleep_wr_i) asleep_q <= sleep_i;
      if (dis_wr_i)   dis_q    <= dis_i;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign elig_o[g] = !asleep_q && grp_en_i[g] && !dis_q[g];
    AST_ELIG_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig_o[g] |-> grp_en_i[g]); // R9
  end

  AST_ASLEEP_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_q |-> elig_o == '0); // R9
  AST_SLEEP_WR_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_wr_i && sleep_i) |=> elig_o == '0); // R11
endmodule

// File: rtl/irq_group_filter.sv
module irq_group_filter
  import irq_group_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned SGI_W = $clog2(NUM_SGI)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sec_dis_i,
  input  logic [NUM_IRQ-1:0]   grp_bits_i,
  input  logic [NUM_IRQ-1:0]   mod_bits_i,
  input  logic [2*NUM_SGI-1:0] nsacc_i,
  input  logic [2:0]           grp_en_i,
  input  logic                 sleep_wr_i,
  input  logic                 sleep_i,
  input  logic                 dis_wr_i,
  input  logic [2:0]           dis_i,
  input  logic                 sgi_req_i,
  input  logic [SGI_W-1:0]     sgi_id_i,
  input  logic [1:0]           sgi_grp_i,
  input  logic                 sgi_ns_i,
  input  logic [NUM_SGI-1:0]   sgi_clr_i,
  output logic [2*NUM_IRQ-1:0] irq_grp_o,
  output logic                 sgi_acc_o,
  output logic                 sgi_drop_o,
  output logic [NUM_SGI-1:0]   sgi_pend_o,
  output logic [2:0]           elig_o
);
  logic [1:0] tgt_grp;

  irq_grp_resolve #(.NUM_IRQ(NUM_IRQ)) u_resolve (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_dis_i  (sec_dis_i),
    .grp_bits_i (grp_bits_i),
    .mod_bits_i (mod_bits_i),
    .grp_o      (irq_grp_o)
  );

  assign tgt_grp = irq_grp_o[{sgi_id_i, 1'b0} +: 2];

  sgi_filter #(.NUM_SGI(NUM_SGI)) u_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_dis_i (sec_dis_i),
    .tgt_grp_i (tgt_grp),
    .nsacc_i   (nsacc_i),
    .req_i     (sgi_req_i),
    .id_i      (sgi_id_i),
    .req_grp_i (sgi_grp_i),
    .ns_i      (sgi_ns_i),
    .clr_i     (sgi_clr_i),
    .acc_o     (sgi_acc_o),
    .drop_o    (sgi_drop_o),
    .pend_o    (sgi_pend_o)
  );

  elig_unit u_elig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grp_en_i   (grp_en_i),
    .sleep_wr_i (sleep_wr_i),
    .sleep_i    (sleep_i),
    .dis_wr_i   (dis_wr_i),
    .dis_i      (dis_i),
    .elig_o     (elig_o)
  );

  initial begin
    assert (NUM_SGI <= NUM_IRQ); // R1
  end
endmodule

// File: tb/irq_group_filter_test.sv
module irq_group_filter_test;
  localparam int NUM_IRQ = 32;
  localparam int NUM_SGI = 16;
  localparam int SGI_W   = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sec_dis;
  logic [NUM_IRQ-1:0] grp_bits, mod_bits;
  logic [2*NUM_SGI-1:0] nsacc;
  logic [2:0] grp_en, dis;
  logic sleep_wr, sleep, dis_wr, req, ns;
  logic [SGI_W-1:0] id;
  logic [1:0] rgrp;
  logic [NUM_SGI-1:0] clr;
  logic [2*NUM_IRQ-1:0] irq_grp;
  logic acc, drop;
  logic [NUM_SGI-1:0] pend;
  logic [2:0] elig;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_group_filter #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sec_dis_i(sec_dis), .grp_bits_i(grp_bits),
    .mod_bits_i(mod_bits), .nsacc_i(nsacc), .grp_en_i(grp_en),
    .sleep_wr_i(sleep_wr), .sleep_i(sleep), .dis_wr_i(dis_wr), .dis_i(dis),
    .sgi_req_i(req), .sgi_id_i(id), .sgi_grp_i(rgrp), .sgi_ns_i(ns),
    .sgi_clr_i(clr), .irq_grp_o(irq_grp), .sgi_acc_o(acc), .sgi_drop_o(drop),
    .sgi_pend_o(pend), .elig_o(elig)
  );

  task automatic check(string req_tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  function automatic int exp_grp(int sd, int m, int g);
    if (sd != 0) return (g != 0) ? 2 : 0;
    return (g != 0) ? 2 : ((m != 0) ? 1 : 0);
  endfunction

  function automatic int exp_acc(int sd, int tg, int rq, int n, int lvl);
    int eff;
    if (rq == 3) return 0;
    eff = (tg == 0 && rq == 1) ? 0 : rq;
    if (eff == 0 && tg != 0) return 0;
    if (n != 0 && sd == 0) begin
      if (tg == 0 && lvl < 1) return 0;
      if (tg == 1 && lvl < 2) return 0;
    end
    return 1;
  endfunction

  task automatic clear_all();
    @(negedge clk); clr = '1;
    @(negedge clk); clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    sec_dis = 0; grp_bits = '0; mod_bits = '0; nsacc = '0; grp_en = 3'b111;
    dis = '0; sleep_wr = 0; sleep = 0; dis_wr = 0; req = 0; ns = 0; id = '0;
    rgrp = '0; clr = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 pend", 64'(pend), 0);
    check("R10 asleep", 64'(elig), 0);
    check("R7 idle", 64'({acc, drop}), 0);
    // R11 wake latency
    sleep_wr = 1; sleep = 0;
    #1 check("R11 before edge", 64'(elig), 0);
    @(negedge clk); sleep_wr = 0;
    check("R10 disable clear", 64'(elig), 64'h7);

    // R1 R2 R3 decode sweep
    for (int sd = 0; sd < 2; sd++)
      for (int p = 0; p < 4; p++) begin
        sec_dis = sd[0];
        mod_bits = {NUM_IRQ{p[1]}};
        grp_bits = {NUM_IRQ{p[0]}};
        #1;
        for (int k = 0; k < NUM_IRQ; k++)
          check(sd ? "R2 decode" : "R3 decode", 64'(irq_grp[2*k +: 2]),
                64'(exp_grp(sd, p[1], p[0])));
      end
    sec_dis = 0;
    grp_bits = 32'hA5C3_0F96; mod_bits = 32'h3C69_F00F;
    #1;
    for (int k = 0; k < NUM_IRQ; k++)
      check("R1 mixed decode", 64'(irq_grp[2*k +: 2]),
            64'(exp_grp(0, mod_bits[k], grp_bits[k])));

    // R4 R5 R6 R7 R8 accept matrix
    for (int c = 0; c < 256; c++) begin
      int sd, m, g, rq, n, lvl, k, tg, ea;
      logic [NUM_SGI-1:0] onehot;
      sd = c & 1; m = (c >> 1) & 1; g = (c >> 2) & 1; rq = (c >> 3) & 3;
      n = (c >> 5) & 1; lvl = (c >> 6) & 3; k = c % NUM_SGI;
      tg = exp_grp(sd, m, g);
      ea = exp_acc(sd, tg, rq, n, lvl);
      onehot = NUM_SGI'(1) << k;
      clear_all();
      sec_dis = sd[0];
      grp_bits = g ? NUM_IRQ'(onehot) : ~NUM_IRQ'(onehot);
      mod_bits = m ? NUM_IRQ'(onehot) : ~NUM_IRQ'(onehot);
      nsacc = '0;
      for (int j = 0; j < NUM_SGI; j++) nsacc[2*j +: 2] = (j == k) ? lvl[1:0] : ~lvl[1:0];
      id = SGI_W'(k); rgrp = rq[1:0]; ns = n[0]; req = 1;
      #1;
      check("R4 R5 R6 accept", 64'(acc), 64'(ea));
      check("R7 drop", 64'(drop), 64'(1 - ea));
      @(negedge clk); req = 0;
      check("R8 pending", 64'(pend), ea ? 64'(onehot) : 0);
    end

    // R8 set wins over clear; drop keeps pend; clear works
    sec_dis = 1; grp_bits = '1; mod_bits = '0; nsacc = '0; ns = 0;
    clear_all();
    @(negedge clk); id = 4'd3; rgrp = 2'd2; req = 1; clr = '1;
    @(negedge clk); req = 0; clr = '0;
    check("R8 set over clear", 64'(pend), 64'h8);
    id = 4'd3; rgrp = 2'd0; req = 1;
    #1 check("R5 drop g0 req", 64'(drop), 1);
    @(negedge clk); req = 0;
    check("R8 drop keeps pend", 64'(pend), 64'h8);
    clr = 16'h0008;
    @(negedge clk); clr = '0;
    check("R8 clear", 64'(pend), 0);

    // R9 R11 eligibility sweep
    for (int c = 0; c < 128; c++) begin
      int sl, dv, ev, ex;
      sl = c & 1; dv = (c >> 1) & 7; ev = (c >> 4) & 7;
      sleep_wr = 1; sleep = sl[0]; dis_wr = 1; dis = dv[2:0]; grp_en = ev[2:0];
      @(negedge clk); sleep_wr = 0; dis_wr = 0;
      ex = sl ? 0 : (ev & ~dv & 7);
      check("R9 eligibility", 64'(elig), 64'(ex));
    end
    // R11 disable latency
    sleep_wr = 1; sleep = 0; dis_wr = 1; dis = 0; grp_en = 3'b111;
    @(negedge clk); sleep_wr = 0;
    dis = 3'b101;
    #1 check("R11 dis before edge", 64'(elig), 64'h7);
    @(negedge clk); dis_wr = 0;
    check("R11 dis after edge", 64'(elig), 64'h2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule